// File: doc/BRIEF.md
# Memory-Card Host Interrupt Status Register

This block gathers every interrupt source of a memory-card host controller into one 8-bit read-only status byte. Four sources are sticky events: the end of a response, the end of a command, the end of a data frame (stream or block), and any change of the card busy level. Each of these flags stays set until the host reads the register. The other four bits follow the state of two data FIFOs under hardware control. Each FIFO is tracked by a two-state machine that records whether the FIFO last reached full or last reached empty.

The read value is presented combinationally while the read strobe is high. The clearing takes effect at the clock edge that ends the read cycle, so the host always sees the value as it stood before the clear. An 8-bit enable mask selects which flags drive the single interrupt request line.

The FIFO tracker (`cardirq_fifo_track`) has two named states. `FT_LAST_EMPTY` is the reset state, with the empty flag set and the full flag clear. `FT_LAST_FULL` has the full flag set and the empty flag clear. The tracker moves from `FT_LAST_EMPTY` to `FT_LAST_FULL` when the FIFO full input is high. It moves from `FT_LAST_FULL` to `FT_LAST_EMPTY` when the FIFO empty input is high. In any other case it holds its state.

The busy edge detector (`cardirq_busy_edge`) also has two states, `BE_LOW` and `BE_HIGH`, which hold the last synchronized busy level. When the synchronized level disagrees with the state, the detector emits one edge pulse and the state follows the level at the next clock. From `BE_LOW` it moves to `BE_HIGH` on a rising edge. From `BE_HIGH` it moves to `BE_LOW` on a falling edge.

Top module: `cardirq_status`

## Requirements
- R1: After reset the read value is 8'h03: both FIFO-empty flags are set and every other flag is clear.
- R2: Bit positions from bit 7 down to bit 0 are: busy change, response done, command done, frame done, FIFO2 full, FIFO1 full, FIFO2 empty, FIFO1 empty. FIFO index 0 of the vector ports is FIFO1 and index 1 is FIFO2.
- R3: A one-cycle strobe on the response, command or frame input sets its flag (bit 6, 5 or 4) at the next clock edge. The flag stays set while no read occurs.
- R4: While the read strobe is high, the read value shows the current flags in the same cycle. At that clock edge bits 7..4 clear.
- R5: If an event strobe coincides with a read, the read shows the old value of that flag, and the flag is set after the edge.
- R6: A rising or a falling edge of the busy input sets bit 7. The busy input passes through two synchronizer flops, so the flag appears at the third clock edge after the input changes and is still clear after the second.
- R7: A FIFO full flag (bit 3 or 2) sets when that FIFO's full input is high. It is not cleared by reads or by the full input dropping. It clears only when that FIFO's empty input is high.
- R8: A FIFO empty flag (bit 1 or 0) sets when that FIFO's empty input is high. It is not cleared by reads or by the empty input dropping. It clears only when that FIFO's full input is high.
- R9: The interrupt request is high exactly when at least one flag bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resp_done_i | input | 1 | Response reception finished (strobe) |
| cmd_done_i | input | 1 | Command transmission finished (strobe) |
| frame_done_i | input | 1 | Data frame transfer finished (strobe) |
| card_busy_i | input | 1 | Asynchronous card busy level |
| fifo_full_i | input | 2 | FIFO full indications, index 0 is FIFO1 |
| fifo_empty_i | input | 2 | FIFO empty indications, index 0 is FIFO1 |
| host_rd_i | input | 1 | Host read strobe, clears event flags at the edge |
| irq_mask_i | input | 8 | Per-bit interrupt enable |
| rd_data_o | output | 8 | Status read value |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The assertions check three things on every cycle. An event strobe always leaves its flag set at the next edge, even during a read. A read with no new event clears the event flags. Each FIFO flag holds unless its opposite condition arrives.

Only the bench's scenarios can show the rest. These are the exact latency of the busy synchronizer, the fact that the read value is the pre-clear value, and the bit layout as a whole. They also include the way a FIFO flag ignores reads and ignores intermediate fill levels, and the masked interrupt under several mask patterns.

// File: rtl/cardirq_pkg.sv
package cardirq_pkg;
    localparam int unsigned NUM_FIFO  = 2;
    localparam int unsigned NUM_EVENT = 4;
    localparam int unsigned REG_W     = NUM_EVENT + 2 * NUM_FIFO;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        FT_LAST_EMPTY = 1'b0,
        FT_LAST_FULL  = 1'b1
    } fifo_trk_e;

    typedef enum logic {
        BE_LOW  = 1'b0,
        BE_HIGH = 1'b1
    } busy_st_e;
endpackage

// File: rtl/cardirq_busy_edge.sv
module cardirq_busy_edge
    import cardirq_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              busy_sync;
    busy_st_e          state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], busy_async_i};
    end
    assign busy_sync = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BE_LOW;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        edge_o  = 1'b0;
        unique case (state_q)
            BE_LOW: begin
                if (busy_sync) begin
                    state_d = BE_HIGH;
                    edge_o  = 1'b1;
                end
            end
            BE_HIGH: begin
                if (!busy_sync) begin
                    state_d = BE_LOW;
                    edge_o  = 1'b1;
                end
            end
        endcase
    end

    assert_edge_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o || $changed(busy_sync));
endmodule

// File: rtl/cardirq_fifo_track.sv
module cardirq_fifo_track
    import cardirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic empty_i,
    output logic full_flag_o,
    output logic empty_flag_o
);
    fifo_trk_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FT_LAST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FT_LAST_EMPTY: if (full_i)  state_d = FT_LAST_FULL;
            FT_LAST_FULL:  if (empty_i) state_d = FT_LAST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full_flag_o  = 1'b0;
        empty_flag_o = 1'b0;
        unique case (state_q)
            FT_LAST_EMPTY: empty_flag_o = 1'b1;
            FT_LAST_FULL:  full_flag_o  = 1'b1;
        endcase
    end

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag_o && !empty_i) |=> full_flag_o);
    assert_full_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_i && !empty_i) |=> full_flag_o);
    assert_empty_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_flag_o && !full_i) |=> empty_flag_o);
endmodule

// File: rtl/cardirq_event_flags.sv
module cardirq_event_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_o[i] <= 1'b0;
            else if (set_i[i])  flag_o[i] <= 1'b1;   // set wins over read clear
            else if (clr_i)     flag_o[i] <= 1'b0;
        end

        assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);
        assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flag_o[i]);
        assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !clr_i) |=> flag_o[i]);
    end
endmodule

// File: rtl/cardirq_status.sv
module cardirq_status
    import cardirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                resp_done_i,
    input  logic                cmd_done_i,
    input  logic                frame_done_i,
    input  logic                card_busy_i,
    input  logic [NUM_FIFO-1:0] fifo_full_i,
    input  logic [NUM_FIFO-1:0] fifo_empty_i,
    input  logic                host_rd_i,
    input  logic [REG_W-1:0]    irq_mask_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic                irq_o
);
    logic                 busy_edge;
    logic [NUM_EVENT-1:0] ev_set, ev_flag;
    logic [NUM_FIFO-1:0]  full_flag, empty_flag;

    cardirq_busy_edge #(.STAGES(SYNC_STAGES)) u_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_async_i (card_busy_i),
        .edge_o       (busy_edge)
    );

    // event order defines bits 7..4
    assign ev_set = {busy_edge, resp_done_i, cmd_done_i, frame_done_i};

    cardirq_event_flags #(.N(NUM_EVENT)) u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (host_rd_i),
        .flag_o (ev_flag)
    );

    for (genvar f = 0; f < NUM_FIFO; f++) begin : g_fifo
        cardirq_fifo_track u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .full_i       (fifo_full_i[f]),
            .empty_i      (fifo_empty_i[f]),
            .full_flag_o  (full_flag[f]),
            .empty_flag_o (empty_flag[f])
        );
    end

    assign rd_data_o = {ev_flag, full_flag, empty_flag};
    assign irq_o     = |(rd_data_o & irq_mask_i);

    assert_busy_edge_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_edge |=> rd_data_o[REG_W-1]);
    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_mask_i != '0) && (rd_data_o != '0));
endmodule

// File: tb/cardirq_status_test.sv
module cardirq_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       resp_done = 1'b0, cmd_done = 1'b0, frame_done = 1'b0;
    logic       busy = 1'b0;
    logic [1:0] ffull = 2'b00, fempty = 2'b11;
    logic       rd = 1'b0;
    logic [7:0] mask = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cardirq_status uut (
        .clk(clk), .rst_n(rst_n),
        .resp_done_i(resp_done), .cmd_done_i(cmd_done), .frame_done_i(frame_done),
        .card_busy_i(busy), .fifo_full_i(ffull), .fifo_empty_i(fempty),
        .host_rd_i(rd), .irq_mask_i(mask),
        .rd_data_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic read_clear();
        rd = 1'b1; step(); rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset value", rdata, 8'h03);
        chk("R9 irq masked off", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_events();
        resp_done = 1'b1; step(); resp_done = 1'b0;
        chk("R3 R2 response bit6", rdata, 8'h43);
        cmd_done = 1'b1; step(); cmd_done = 1'b0;
        chk("R3 R2 command bit5", rdata, 8'h63);
        frame_done = 1'b1; step(); frame_done = 1'b0;
        chk("R3 R2 frame bit4", rdata, 8'h73);
        step(); step();
        chk("R3 flags sticky", rdata, 8'h73);
    endtask

    task automatic t_read_clear();
        rd = 1'b1; #1;
        chk("R4 same-cycle read value", rdata, 8'h73);
        step(); rd = 1'b0;
        chk("R4 cleared after read", rdata, 8'h03);
    endtask

    task automatic t_collide();
        rd = 1'b1; cmd_done = 1'b1; #1;
        chk("R5 read shows old value", rdata, 8'h03);
        step(); rd = 1'b0; cmd_done = 1'b0;
        chk("R5 event kept", rdata, 8'h23);
        read_clear();
        chk("R5 later read clears", rdata, 8'h03);
    endtask

    task automatic t_busy();
        busy = 1'b1;
        step(); step();
        chk("R6 rise not before third edge", rdata, 8'h03);
        step();
        chk("R6 rising edge flagged", rdata, 8'h83);
        read_clear();
        chk("R6 busy flag cleared by read", rdata, 8'h03);
        step(); step();
        chk("R6 steady high no flag", rdata, 8'h03);
        busy = 1'b0;
        step(); step(); step();
        chk("R6 falling edge flagged", rdata, 8'h83);
        read_clear();
    endtask

    task automatic t_fifo();
        fempty = 2'b10; step();
        chk("R8 empty flag holds when not empty", rdata, 8'h03);
        ffull = 2'b01; step();
        chk("R7 R8 fifo1 full", rdata, 8'h06);
        read_clear();
        chk("R7 full not cleared by read", rdata, 8'h06);
        ffull = 2'b00; step();
        chk("R7 full holds when draining", rdata, 8'h06);
        fempty = 2'b11; step();
        chk("R7 R8 fifo1 empty again", rdata, 8'h03);
        fempty = 2'b01; ffull = 2'b10; step();
        chk("R7 R8 fifo2 full", rdata, 8'h09);
        ffull = 2'b00; step();
        chk("R7 fifo2 full holds", rdata, 8'h09);
        fempty = 2'b11; step();
        chk("R8 fifo2 empty again", rdata, 8'h03);
    endtask

    task automatic t_irq();
        mask = 8'h01; #1;
        chk("R9 irq from fifo1 empty", {7'd0, irq}, 8'h01);
        mask = 8'hFC; #1;
        chk("R9 irq off when unmasked bits clear", {7'd0, irq}, 8'h00);
        frame_done = 1'b1; step(); frame_done = 1'b0;
        mask = 8'h10; #1;
        chk("R9 irq from frame flag", {7'd0, irq}, 8'h01);
        read_clear();
        chk("R9 irq drops after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_events();
        t_read_clear();
        t_collide();
        t_busy();
        t_fifo();
        t_irq();
        finish_run();
    end
endmodule